// File: doc/BRIEF.md
# Two-Channel Count-Up Compare Watchdog

This block holds two watchdog channels behind a small 32-bit register bus. A shared prescaler turns the system clock into a one-cycle pulse every 10 ms. On each pulse, every channel's up-counter advances by one. Each channel compares its counter with a limit that software programs. When the counter equals the limit, the channel is expired. The counter then stops and keeps its value until software writes that channel's register again. That write zeroes the counter and loads a new limit.

Channel 0 also holds a reset-enable bit. While channel 0 is expired and this bit is set, the block drives a chip-wide reset request. Per-channel mask inputs hide a channel's expiry output. Software uses the block by programming a limit and then rewriting the register before the limit is reached. A read returns the live counter together with the programmed fields.

Top module: `cuw_top`

## Requirements
- R1: After reset, each channel has a count of 0, a limit of 32767 and reset-enable 0, and both `expired` and `reset_req` are low.
- R2: The count (read bits 14:0) rises by exactly one on each prescaler tick, one tick every `TICK_DIV` clock cycles, while the channel is not expired.
- R3: A channel is expired when its count equals its limit. While expired its count holds its value across further ticks.
- R4: Writing a channel (`bus_wr` with `bus_addr` = channel number) clears its count to zero, loads the limit from write bits 30:16, and ends expiry in the same edge.
- R5: A read strobe captures the addressed channel into `bus_rdata` one edge later as {reset-enable in bit 31, limit in bits 30:16, 0 in bit 15, count in bits 14:0}.
- R6: `reset_req` is high exactly while channel 0 is expired with its reset-enable (write bit 31) set. With the enable at 0, expiry gives no request.
- R7: Channel 1 ignores write bit 31. It reads back 0 in bit 31, and its expiry never raises `reset_req`.
- R8: With `exp_mask[i]` high, `expired[i]` stays low, while the count still freezes and `reset_req` still follows channel 0's expiry.
- R9: A limit of 0 makes the channel expired right after the writing edge, without waiting for a tick.
- R10: A write to one channel leaves the other channel's count and fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | ADDR_W | Channel select (0 or 1) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data: bit 31 reset-enable, bits 30:16 limit |
| bus_rdata | output | 32 | Registered read data |
| exp_mask | input | NUM_CH | Per-channel expiry mask, 1 hides the expiry output |
| expired | output | NUM_CH | Per-channel expiry, masked |
| reset_req | output | 1 | Chip reset request from channel 0, active high |

## Verification
The counters are run to several limits, including 0, 2, 3 and values far above the waiting time. This separates correct per-tick stepping from freezing at the limit and from instant expiry. Reset-enable is tried both set and clear, and on channel 1 as well as channel 0, so that a request that follows expiry alone, or that comes from the wrong channel, shows up. Interleaved writes to both channels, with reads taken at whole-tick multiples after a write, show whether a write clears only its own channel and whether the tick phase leaks into the count.

// File: rtl/cuw_pkg.sv
package cuw_pkg;
  localparam int DATA_W  = 32;
  localparam int CNT_W   = 15;
  localparam int LIM_LSB = 16;
  localparam int EN_BIT  = 31;
endpackage

// File: rtl/cuw_tick_gen.sv
module cuw_tick_gen #(
  parameter int TICK_DIV = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int PS_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PS_W-1:0] LAST = PS_W'(TICK_DIV - 1);

  logic [PS_W-1:0] ps_q, ps_d;

  always_comb begin
    if (ps_q == LAST) ps_d = '0;
    else              ps_d = ps_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ps_q <= '0;
    else        ps_q <= ps_d;
  end

  assign tick = (ps_q == LAST);
endmodule

// File: rtl/cuw_channel.sv
module cuw_channel #(
  parameter int CNT_W   = 15,
  parameter bit HAS_RST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_limit,
  input  logic             wr_rst_en,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             rst_en_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W-1:0] limit_q;
  logic             hit;
  logic             cnt_ce;

  assign hit    = (count_q == limit_q);
  assign cnt_ce = wr_en | (tick & ~hit);

  always_comb begin
    if (wr_en) count_d = '0;
    else       count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_ce) count_q <= count_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     limit_q <= '1;
    else if (wr_en) limit_q <= wr_limit;
  end

  generate
    if (HAS_RST) begin : g_rst_en
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_en) en_q <= wr_rst_en;
      end
      assign rst_en_o = en_q;
    end else begin : g_no_rst_en
      logic unused_en;
      assign unused_en = wr_rst_en;
      assign rst_en_o  = 1'b0;
    end
  endgenerate

  assign count_o = count_q;
  assign limit_o = limit_q;
  assign hit_o   = hit;
endmodule

// File: rtl/cuw_top.sv
module cuw_top #(
  parameter int TICK_DIV = 1250000,
  parameter int NUM_CH   = 2,
  parameter int ADDR_W   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [cuw_pkg::DATA_W-1:0] bus_wdata,
  output logic [cuw_pkg::DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0]         exp_mask,
  output logic [NUM_CH-1:0]         expired,
  output logic                      reset_req
);
  import cuw_pkg::*;

  logic                           tick;
  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_a;
  logic [NUM_CH-1:0][CNT_W-1:0]   lim_a;
  logic [NUM_CH-1:0]              en_a;
  logic [NUM_CH-1:0]              hit_a;
  logic [NUM_CH-1:0]              wr_sel;
  logic [DATA_W-1:0]              rdata_q, rdata_d;
  logic                           unused_wdata;

  assign unused_wdata = ^bus_wdata[LIM_LSB-1:0];

  cuw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign wr_sel[i] = bus_wr && (bus_addr == ADDR_W'(i));
      cuw_channel #(.CNT_W(CNT_W), .HAS_RST(i == 0)) u_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wr_en    (wr_sel[i]),
        .wr_limit (bus_wdata[LIM_LSB +: CNT_W]),
        .wr_rst_en(bus_wdata[EN_BIT]),
        .count_o  (cnt_a[i]),
        .limit_o  (lim_a[i]),
        .rst_en_o (en_a[i]),
        .hit_o    (hit_a[i])
      );
    end
  endgenerate

  always_comb begin
    rdata_d = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(i)) begin
        rdata_d[CNT_W-1:0]          = cnt_a[i];
        rdata_d[LIM_LSB +: CNT_W]   = lim_a[i];
        rdata_d[EN_BIT]             = en_a[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign expired   = hit_a & ~exp_mask;
  assign reset_req = hit_a[0] & en_a[0];
endmodule

// File: rtl/cuw_checker.sv
module cuw_checker #(
  parameter int ADDR_W = 1,
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] exp_mask,
  input logic [NUM_CH-1:0] expired,
  input logic              reset_req,
  input logic [14:0]       cnt0,
  input logic              hit0
);
  logic wr0;
  assign wr0 = bus_wr && (bus_addr == '0);

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr0 && !hit0) |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 15'd1));

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit0 && !wr0) |=> $stable(cnt0));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr0 |=> (cnt0 == 15'd0));

  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata[15]);

  p_req_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> hit0);

  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exp_mask[0] |-> !expired[0]);

  p_zero_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_wdata[30:16] == 15'd0) |=> hit0);
endmodule

bind cuw_top cuw_checker #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .exp_mask (exp_mask),
  .expired  (expired),
  .reset_req(reset_req),
  .cnt0     (cnt_a[0]),
  .hit0     (hit_a[0])
);

// File: tb/cuw_top_tb.sv
module cuw_top_tb;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [0:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  exp_mask, expired;
  logic        reset_req;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cuw_top #(.TICK_DIV(DIV), .NUM_CH(2), .ADDR_W(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .exp_mask(exp_mask), .expired(expired), .reset_req(reset_req)
  );

  function automatic logic [31:0] word(input logic en, input int lim, input int cnt);
    word = {en, lim[14:0], 1'b0, cnt[14:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write edge; returns at the negedge after it
  task automatic wr(input int ch, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ch[0]; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read captures state present now; consumes DIV edges in total
  task automatic rd(input int ch, input logic [31:0] exp, input string tag);
    bus_addr = ch[0]; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
    idle(DIV - 1);
  endtask

  task automatic t_reset;
    check("R1 expired", {30'd0, expired}, 32'd0);
    check("R1 reset_req", {31'd0, reset_req}, 32'd0);
    bus_addr = 1'b0; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check("R1 R5 ch0 fields", {bus_rdata[31:15], 15'd0}, word(1'b0, 32767, 0));
    bus_addr = 1'b1; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check("R1 R5 ch1 fields", {bus_rdata[31:15], 15'd0}, word(1'b0, 32767, 0));
  endtask

  task automatic t_count;
    wr(0, word(1'b0, 100, 0));
    idle(5 * DIV);
    rd(0, word(1'b0, 100, 5), "R2 R4 count five ticks");
    idle(2 * DIV);
    rd(0, word(1'b0, 100, 8), "R2 count eight ticks");
  endtask

  task automatic t_expire;
    wr(0, word(1'b1, 3, 0));
    idle(2 * DIV);
    check("R3 not yet expired", {30'd0, expired}, 32'd0);
    idle(DIV);
    check("R3 expired at limit", {31'd0, expired[0]}, 32'd1);
    check("R6 reset_req with enable", {31'd0, reset_req}, 32'd1);
    rd(0, word(1'b1, 3, 3), "R5 readback at limit");
    idle(3 * DIV);
    rd(0, word(1'b1, 3, 3), "R3 count frozen");
    wr(0, word(1'b1, 3, 0));
    check("R4 write ends expiry", {31'd0, expired[0]}, 32'd0);
    check("R4 write drops reset_req", {31'd0, reset_req}, 32'd0);
  endtask

  task automatic t_no_enable;
    wr(0, word(1'b0, 2, 0));
    idle(2 * DIV);
    check("R6 expired without enable", {31'd0, expired[0]}, 32'd1);
    check("R6 no request without enable", {31'd0, reset_req}, 32'd0);
  endtask

  task automatic t_zero;
    wr(0, word(1'b1, 0, 0));
    check("R9 zero limit expired", {31'd0, expired[0]}, 32'd1);
    check("R9 zero limit request", {31'd0, reset_req}, 32'd1);
    idle(2 * DIV);
    rd(0, word(1'b1, 0, 0), "R9 count stays zero");
  endtask

  task automatic t_mask;
    exp_mask = 2'b01;
    wr(0, word(1'b1, 1, 0));
    idle(2 * DIV);
    check("R8 masked expiry low", {31'd0, expired[0]}, 32'd0);
    check("R8 request despite mask", {31'd0, reset_req}, 32'd1);
    rd(0, word(1'b1, 1, 1), "R8 count frozen under mask");
    exp_mask = 2'b00;
    #1;
    check("R8 unmasked expiry", {31'd0, expired[0]}, 32'd1);
  endtask

  task automatic t_ch1;
    wr(0, word(1'b0, 32767, 0));
    idle(DIV - 1);
    wr(1, word(1'b1, 2, 0));
    idle(2 * DIV);
    check("R7 ch1 expired", {31'd0, expired[1]}, 32'd1);
    check("R7 ch1 no request", {31'd0, reset_req}, 32'd0);
    check("R10 ch0 not expired", {31'd0, expired[0]}, 32'd0);
    rd(1, word(1'b0, 2, 2), "R7 ch1 bit31 reads zero");
    rd(0, word(1'b0, 32767, 4), "R10 ch0 count undisturbed");
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; exp_mask = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_count();
    t_expire();
    t_no_enable();
    t_zero();
    t_mask();
    t_ch1();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule